// File: doc/BRIEF.md
# Frame Coincidence Sequence Marker

This block watches two independent video timing streams and produces a logic-level marker whenever their frames line up. Each stream supplies two single-cycle strobes: one at the start of its first line and one at the start of each field. When the first-line strobes of the two streams arrive together, the marker goes high. It stays high for exactly one field of the stream with the higher frame rate. For the usual pairs of high- and standard-definition rates, this gives a marker that repeats at a few hertz, commonly 6 Hz or 1 Hz.

Two streams whose rates are not related in a simple way rarely produce strobes on exactly the same clock edge. For that reason, "together" has a tolerance: the two first-line strobes may be up to `WIN` cycles apart, in either order. A configuration input states which stream is the faster one. The block samples that input when a marker starts. The marker ends at the next field strobe of the chosen stream. The output is a plain digital level and carries no sync waveform.

Top module: `seq_pulse_gen`

## Requirements
- R1: While reset is applied, and after it is released, `seq_pulse` is low until a coincidence occurs.
- R2: If `a_line1` and `b_line1` are high in the same cycle while the marker is idle, `seq_pulse` is high from the next cycle on.
- R3: If the second first-line strobe follows the first by 1 to `WIN` cycles (default 4), in either order, `seq_pulse` rises in the cycle after the later strobe.
- R4: If the two first-line strobes are more than `WIN` cycles apart, `seq_pulse` stays low.
- R5: `seq_pulse` falls in the cycle after a field strobe of the faster stream. A field strobe of the slower stream does not end it.
- R6: `fast_sel` = 0 names stream A (`a_field`) as the faster stream, and `fast_sel` = 1 names stream B (`b_field`). The value is sampled in the cycle that starts the marker and is held until the marker ends.
- R7: A coincidence that occurs while the marker is high neither restarts nor extends it.
- R8: `clr` is a synchronous clear. It drives `seq_pulse` low in the next cycle and discards any first-line strobe that is still waiting for its partner.
- R9: Each first-line strobe takes part in at most one coincidence. Once a strobe has been matched, a later strobe of the other stream within `WIN` cycles of it does not start a new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous clear of the marker and of pending window state |
| a_line1 | input | 1 | Stream A first-line strobe |
| a_field | input | 1 | Stream A field-start strobe |
| b_line1 | input | 1 | Stream B first-line strobe |
| b_field | input | 1 | Stream B field-start strobe |
| fast_sel | input | 1 | Faster stream: 0 = A, 1 = B |
| seq_pulse | output | 1 | Logic-level sequence marker |

## Verification
The bound checker covers the rules that can be seen from the ports in every cycle:
- same-cycle strobes start the marker;
- the marker never starts without a first-line strobe;
- a clear always drops the marker;
- the marker never falls without a field strobe or a clear;
- the marker holds while there are no field strobes.

The bench's scenarios cover the behaviour that depends on history:
- the tolerance window and its exact edge;
- which stream's field strobe ends the marker, and the sampling of the select input;
- consumption of matched strobes;
- loss of a pending strobe on a clear.

// File: rtl/seq_pulse_pkg.sv
package seq_pulse_pkg;
  typedef enum logic {
    MK_IDLE   = 1'b0,
    MK_ACTIVE = 1'b1
  } mk_state_t;

  localparam int unsigned NUM_STREAMS = 2;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/seq_line1_tracker.sv
// Remembers one stream's first-line strobe for WIN cycles after it occurs.
module seq_line1_tracker #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe_i,
  input  logic consume_i,
  output logic recent_o
);
  localparam int CW = (WIN < 2) ? 1 : $clog2(WIN + 1);
  localparam logic [CW-1:0] AGE_LAST = CW'(WIN);
  localparam logic [CW-1:0] AGE_ONE  = CW'(1);

  logic          pend_q, pend_d;
  logic [CW-1:0] age_q, age_d;
  logic          en;

  always_comb begin
    pend_d = pend_q;
    age_d  = age_q;
    if (clr || consume_i) begin
      pend_d = 1'b0;
      age_d  = '0;
    end else if (strobe_i) begin
      pend_d = 1'b1;
      age_d  = AGE_ONE;
    end else if (pend_q) begin
      if (age_q == AGE_LAST) pend_d = 1'b0;
      else                   age_d  = age_q + AGE_ONE;
    end
  end

  assign en = clr || consume_i || strobe_i || pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else if (en) begin
      pend_q <= pend_d;
      age_q  <= age_d;
    end
  end

  assign recent_o = pend_q;
endmodule

// File: rtl/seq_coinc.sv
// Flags a coincidence of the two first-line strobes within WIN cycles.
module seq_coinc
  import seq_pulse_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [NUM_STREAMS-1:0] line1_i,
  output logic                   coinc_o
);
  logic [NUM_STREAMS-1:0] recent;

  generate
    if (WIN > 0) begin : g_window
      for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_trk
        seq_line1_tracker #(.WIN(WIN)) u_trk (
          .clk       (clk),
          .rst_n     (rst_n),
          .clr       (clr),
          .strobe_i  (line1_i[s]),
          .consume_i (coinc_o),
          .recent_o  (recent[s])
        );
      end
    end else begin : g_exact
      assign recent = '0;
    end
  endgenerate

  assign coinc_o = !clr &&
                   ((line1_i[0] && (line1_i[1] || recent[1])) ||
                    (line1_i[1] && recent[0]));
endmodule

// File: rtl/seq_pulse_ctrl.sv
// Holds the marker from a coincidence to the next field strobe of the faster stream.
module seq_pulse_ctrl
  import seq_pulse_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   start_i,
  input  logic [NUM_STREAMS-1:0] field_i,
  input  logic                   fast_sel_i,
  output logic                   pulse_o
);
  mk_state_t st_q, st_d;
  logic      sel_q, sel_d;
  logic      sel_en;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    sel_en = 1'b0;
    if (clr) begin
      st_d = MK_IDLE;
    end else begin
      unique case (st_q)
        MK_IDLE: if (start_i) begin
          st_d   = MK_ACTIVE;
          sel_d  = fast_sel_i;
          sel_en = 1'b1;
        end
        MK_ACTIVE: if (field_i[sel_q]) st_d = MK_IDLE;
        default: st_d = MK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= MK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign pulse_o = (st_q == MK_ACTIVE);
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen
  import seq_pulse_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic a_line1,
  input  logic a_field,
  input  logic b_line1,
  input  logic b_field,
  input  logic fast_sel,
  output logic seq_pulse
);
  logic                   rst_sync_n;
  logic                   coinc;
  logic [NUM_STREAMS-1:0] line1;
  logic [NUM_STREAMS-1:0] field;

  assign line1 = {b_line1, a_line1};
  assign field = {b_field, a_field};

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seq_coinc #(.WIN(WIN)) u_coinc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clr),
    .line1_i (line1),
    .coinc_o (coinc)
  );

  seq_pulse_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (clr),
    .start_i    (coinc),
    .field_i    (field),
    .fast_sel_i (fast_sel),
    .pulse_o    (seq_pulse)
  );
endmodule

// File: rtl/seq_pulse_chk.sv
module seq_pulse_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic a_line1,
  input logic a_field,
  input logic b_line1,
  input logic b_field,
  input logic seq_pulse
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_line1 && b_line1 && !seq_pulse && !clr) |=> seq_pulse);

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_pulse && !a_line1 && !b_line1) |=> !seq_pulse);

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_pulse) |-> $past(a_field || b_field || clr));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_pulse && !a_field && !b_field && !clr) |=> seq_pulse);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !seq_pulse);
endmodule

bind seq_pulse_gen seq_pulse_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clr       (clr),
  .a_line1   (a_line1),
  .a_field   (a_field),
  .b_line1   (b_line1),
  .b_field   (b_field),
  .seq_pulse (seq_pulse)
);

// File: tb/sim_seq_pulse_gen.sv
`timescale 1ns/1ps
module sim_seq_pulse_gen;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst_n, clr, a_line1, a_field, b_line1, b_field, fast_sel;
  logic seq_pulse;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  seq_pulse_gen #(.WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .a_line1(a_line1), .a_field(a_field),
    .b_line1(b_line1), .b_field(b_field),
    .fast_sel(fast_sel), .seq_pulse(seq_pulse)
  );

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (seq_pulse !== exp) begin
      n_fail++;
      $display("FAIL %s: seq_pulse=%b expected %b at %0t", tag, seq_pulse, exp, $time);
    end
  endtask

  // One clock cycle with the given strobes; returns at the next falling edge.
  task automatic step(input logic al, input logic af, input logic bl, input logic bf, input logic c);
    a_line1 = al; a_field = af; b_line1 = bl; b_field = bf; clr = c;
    @(negedge clk);
    a_line1 = 0; a_field = 0; b_line1 = 0; b_field = 0; clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; clr = 0; fast_sel = 0;
    a_line1 = 0; a_field = 0; b_line1 = 0; b_field = 0;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 during reset");
    rst_n = 1;
    idle(4);
    chk(1'b0, "R1 after reset");
  endtask

  task automatic t_same;
    fast_sel = 0;
    step(1, 1, 1, 0, 0);  chk(1'b1, "R2 same-cycle start");
    idle(3);              chk(1'b1, "R2 held without field strobe");
    step(0, 0, 0, 1, 0);  chk(1'b1, "R5 slow field ignored");
    step(0, 1, 0, 0, 0);  chk(1'b0, "R5 fast field ends");
    idle(WIN + 2);
  endtask

  task automatic t_window_ab;
    fast_sel = 0;
    step(1, 0, 0, 0, 0);  idle(3);
    chk(1'b0, "R3 waiting for partner");
    step(0, 0, 1, 0, 0);  chk(1'b1, "R3 A then B at WIN");
    step(0, 1, 0, 0, 0);  chk(1'b0, "R5 end");
    idle(WIN + 2);
  endtask

  task automatic t_window_ba;
    fast_sel = 1;
    step(0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0);  chk(1'b1, "R3 B then A distance 1");
    step(0, 1, 0, 0, 0);  chk(1'b1, "R6 A field ignored when B fast");
    step(0, 0, 0, 1, 0);  chk(1'b0, "R6 B field ends when B fast");
    idle(WIN + 2);
  endtask

  task automatic t_too_far;
    fast_sel = 0;
    step(1, 0, 0, 0, 0);  idle(WIN);
    step(0, 0, 1, 0, 0);  chk(1'b0, "R4 beyond window");
    idle(2);              chk(1'b0, "R4 stays low");
    idle(WIN + 2);
  endtask

  task automatic t_restart;
    fast_sel = 0;
    step(1, 0, 1, 0, 0);  chk(1'b1, "R7 start");
    step(1, 0, 1, 0, 0);  chk(1'b1, "R7 coincidence while high");
    step(0, 1, 0, 0, 0);  chk(1'b0, "R7 not extended past field");
    idle(WIN + 2);
  endtask

  task automatic t_latch;
    fast_sel = 0;
    step(1, 0, 1, 0, 0);  chk(1'b1, "R6 start with A fast");
    fast_sel = 1;
    step(0, 0, 0, 1, 0);  chk(1'b1, "R6 select held during marker");
    step(0, 1, 0, 0, 0);  chk(1'b0, "R6 sampled stream ends");
    fast_sel = 0;
    idle(WIN + 2);
  endtask

  task automatic t_clr;
    step(1, 0, 1, 0, 0);  chk(1'b1, "R8 start");
    step(0, 0, 0, 0, 1);  chk(1'b0, "R8 clear drops marker");
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0);  chk(1'b0, "R8 pending strobe discarded");
    idle(WIN + 2);
  endtask

  task automatic t_consume;
    fast_sel = 0;
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);  chk(1'b1, "R9 first match");
    step(0, 1, 0, 0, 0);  chk(1'b0, "R9 end");
    step(0, 0, 1, 0, 0);  chk(1'b0, "R9 matched strobe not reused");
    idle(WIN + 2);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_same();
    t_window_ab();
    t_window_ba();
    t_too_far();
    t_restart();
    t_latch();
    t_clr();
    t_consume();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule